// File: doc/BRIEF.md
# SPI FIFO pair with trigger levels

This block sits between the register port of an SPI controller and its shift engine. It holds one byte-wide transmit queue, filled by the host and drained by the engine, and one byte-wide receive queue, filled by the engine and drained by the host. Each queue has a programmable watermark. The transmit side flags a request when it has run low. The receive side flags readiness when it has filled up to its mark. Either condition can drive a DMA request line in place of an interrupt.

The host reaches six word addresses through single-cycle write and read strobes. There is a control word that holds both watermarks, both DMA enables and two self-clearing queue resets. There is a read-only word with both occupancy counts. There are an interrupt-enable word and a sticky write-one-to-clear event word, plus one data port for each queue. The engine pops transmit bytes and pushes receive bytes with single-cycle strobes, and it pulses a completion input at the end of a transfer.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each queue holds DEPTH one-byte entries (DEPTH a power of two, 64 or 128) and returns bytes in the order they were written. A push into a full queue is dropped and leaves the count at DEPTH.
- R2: Host word addresses on `host_addr` are 0 control, 1 levels, 2 interrupt enable, 3 event status, 4 transmit data (a write pushes `host_wdata[7:0]`), and 5 receive data (a read pops). The control word has the receive mark in bits 7:0, receive DMA enable in bit 8, receive reset in bit 15, transmit mark in bits 23:16, transmit DMA enable in bit 24 and transmit reset in bit 31. It reads back as written, with unused bits at 0.
- R3: The levels word carries the receive count in bits 7:0 and the transmit count in bits 23:16. All other bits read 0.
- R4: A reset bit written as 1 reads back as 1 for exactly one cycle. At the following clock edge it clears itself and empties its own queue. The other queue and the marks are unaffected.
- R5: Event bit 0 (receive ready) sets one cycle after the receive count is greater than or equal to the receive mark.
- R6: Event bit 4 (transmit request) sets one cycle after the transmit count is less than or equal to the transmit mark.
- R7: An engine push into a full receive queue drops the byte, leaves the count at DEPTH and sets event bit 8 (receive overflow) at the next edge.
- R8: A pulse on `eng_done` sets event bit 12 (transfer complete) at the next edge.
- R9: Event bits are sticky. Writing 1 to a bit of address 3 clears it, writing 0 leaves it, and writing all ones clears every bit whose condition is absent. A set condition in the same cycle as a clear wins, so a level bit whose condition still holds sets again.
- R10: The interrupt-enable word keeps only bits 0, 4, 8 and 12. `irq` is high exactly when some event bit and its enable are both 1.
- R11: `rx_dma_req` is high while the receive DMA enable is set and the receive count is at or above the receive mark. `tx_dma_req` is high while the transmit DMA enable is set and the transmit count is at or below the transmit mark. Both follow the current counts with no extra register.
- R12: Reading receive data from an empty queue returns 0 and changes no count. `eng_tx_avail` is low when the transmit queue is empty, and a pop while it is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Host word address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops at address 5) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from address |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_tx_byte | output | 8 | Transmit head byte |
| eng_rx_push | input | 1 | Engine writes a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_done | input | 1 | Transfer complete pulse |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block at DEPTH 64, which is the smaller supported size. At that size every fill level from empty to full is affordable on both queues, including the dropped push past full. The receive watermark is swept over 1, 7, 32 and 64, and at each level the event bit and the DMA line are compared against the arithmetic comparison. The transmit mark is exercised at its crossing point, and the sticky, enable and set-versus-clear rules are checked bit by bit.

// File: rtl/spfp_pkg.sv
package spfp_pkg;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_LEVELS = 3'd1,
    A_IEN    = 3'd2,
    A_ISTAT  = 3'd3,
    A_TXD    = 3'd4,
    A_RXD    = 3'd5
  } spfp_addr_e;

  // control word bit positions (software decodes these)
  localparam int RX_MARK_LSB  = 0;
  localparam int RX_DMA_BIT   = 8;
  localparam int RX_FLUSH_BIT = 15;
  localparam int TX_MARK_LSB  = 16;
  localparam int TX_DMA_BIT   = 24;
  localparam int TX_FLUSH_BIT = 31;

  // levels word positions
  localparam int RXCNT_LSB = 0;
  localparam int TXCNT_LSB = 16;

  // event vector: index k lives at word bit 4*k
  localparam int N_EV     = 4;
  localparam int EV_RXRDY = 0;
  localparam int EV_TXREQ = 1;
  localparam int EV_RXOVF = 2;
  localparam int EV_DONE  = 3;

  typedef logic [N_EV-1:0] ev_vec_t;

  typedef struct packed {
    logic       tx_flush;
    logic       tx_dma;
    logic [7:0] tx_mark;
    logic       rx_flush;
    logic       rx_dma;
    logic [7:0] rx_mark;
  } fifo_ctl_t;

  function automatic int ev_pos(input int k);
    return 4 * k;
  endfunction

  function automatic logic [31:0] ev_spread(input ev_vec_t v);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < N_EV; k++) w[ev_pos(k)] = v[k];
    return w;
  endfunction

  function automatic ev_vec_t ev_gather(input logic [31:0] w);
    ev_vec_t v;
    for (int k = 0; k < N_EV; k++) v[k] = w[ev_pos(k)];
    return v;
  endfunction

  function automatic logic rx_ready_f(input logic [7:0] cnt, input logic [7:0] mark);
    return cnt >= mark;
  endfunction

  function automatic logic tx_low_f(input logic [7:0] cnt, input logic [7:0] mark);
    return cnt <= mark;
  endfunction

  function automatic logic [31:0] ctl_pack(input fifo_ctl_t c);
    logic [31:0] w;
    w = '0;
    w[RX_MARK_LSB +: 8] = c.rx_mark;
    w[RX_DMA_BIT]       = c.rx_dma;
    w[RX_FLUSH_BIT]     = c.rx_flush;
    w[TX_MARK_LSB +: 8] = c.tx_mark;
    w[TX_DMA_BIT]       = c.tx_dma;
    w[TX_FLUSH_BIT]     = c.tx_flush;
    return w;
  endfunction

  function automatic fifo_ctl_t ctl_unpack(input logic [31:0] w);
    fifo_ctl_t c;
    c.rx_mark  = w[RX_MARK_LSB +: 8];
    c.rx_dma   = w[RX_DMA_BIT];
    c.rx_flush = w[RX_FLUSH_BIT];
    c.tx_mark  = w[TX_MARK_LSB +: 8];
    c.tx_dma   = w[TX_DMA_BIT];
    c.tx_flush = w[TX_FLUSH_BIT];
    return c;
  endfunction

  function automatic logic [31:0] levels_pack(input logic [7:0] rx_cnt, input logic [7:0] tx_cnt);
    logic [31:0] w;
    w = '0;
    w[RXCNT_LSB +: 8] = rx_cnt;
    w[TXCNT_LSB +: 8] = tx_cnt;
    return w;
  endfunction

endpackage

// File: rtl/spfp_byte_fifo.sv
module spfp_byte_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          drop
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign drop    = push && full && !flush;
  assign dout    = mem[rd_ptr_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/spfp_irq_unit.sv
module spfp_irq_unit
  import spfp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t ev_set,
  input  logic    clr_wr,
  input  ev_vec_t ev_clr,
  input  ev_vec_t ev_en,
  output ev_vec_t ev_q,
  output logic    irq
);

  for (genvar k = 0; k < N_EV; k++) begin : g_ev
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= (q && !(clr_wr && ev_clr[k])) || ev_set[k];
    end
    assign ev_q[k] = q;
  end

  assign irq = |(ev_q & ev_en);

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spfp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        eng_tx_pop,
  output logic        eng_tx_avail,
  output logic [7:0]  eng_tx_byte,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_byte,
  input  logic        eng_done,
  output logic        irq,
  output logic        tx_dma_req,
  output logic        rx_dma_req
);

  localparam int CW = $clog2(DEPTH + 1);

  spfp_addr_e    addr_e;
  fifo_ctl_t     ctl_q;
  ev_vec_t       ien_q;
  ev_vec_t       ev_q;
  ev_vec_t       ev_set;
  logic          ctl_wr, ien_wr, stat_clr_wr, tx_host_push, rx_host_pop;
  logic          rx_flush, tx_flush, rx_dma_en, tx_dma_en;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [7:0]    rx_cnt8, tx_cnt8;
  logic [7:0]    rx_head;
  logic          rx_full, rx_empty, rx_ovf_evt;
  logic          tx_full, tx_empty, tx_drop;
  logic          rx_rdy_cond, tx_req_cond;
  logic [31:0]   stat_word;

  // host decode
  always_comb begin
    addr_e       = spfp_addr_e'(host_addr);
    ctl_wr       = host_wr && (addr_e == A_CTRL);
    ien_wr       = host_wr && (addr_e == A_IEN);
    stat_clr_wr  = host_wr && (addr_e == A_ISTAT);
    tx_host_push = host_wr && (addr_e == A_TXD);
    rx_host_pop  = host_rd && (addr_e == A_RXD);
  end

  // control word, resets self-clear after one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= ctl_unpack(host_wdata);
    end else begin
      ctl_q.rx_flush <= 1'b0;
      ctl_q.tx_flush <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_wr) ien_q <= ev_gather(host_wdata);
  end

  assign rx_flush  = ctl_q.rx_flush;
  assign tx_flush  = ctl_q.tx_flush;
  assign rx_dma_en = ctl_q.rx_dma;
  assign tx_dma_en = ctl_q.tx_dma;

  spfp_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (eng_rx_push),
    .din   (eng_rx_byte),
    .pop   (rx_host_pop),
    .dout  (rx_head),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty),
    .drop  (rx_ovf_evt)
  );

  spfp_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (tx_host_push),
    .din   (host_wdata[7:0]),
    .pop   (eng_tx_pop),
    .dout  (eng_tx_byte),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty),
    .drop  (tx_drop)
  );

  assign rx_cnt8      = 8'(rx_cnt);
  assign tx_cnt8      = 8'(tx_cnt);
  assign eng_tx_avail = !tx_empty;

  // watermark comparators
  assign rx_rdy_cond = rx_ready_f(rx_cnt8, ctl_q.rx_mark);
  assign tx_req_cond = tx_low_f(tx_cnt8, ctl_q.tx_mark);

  always_comb begin
    ev_set           = '0;
    ev_set[EV_RXRDY] = rx_rdy_cond;
    ev_set[EV_TXREQ] = tx_req_cond;
    ev_set[EV_RXOVF] = rx_ovf_evt;
    ev_set[EV_DONE]  = eng_done;
  end

  spfp_irq_unit u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_set (ev_set),
    .clr_wr (stat_clr_wr),
    .ev_clr (ev_gather(host_wdata)),
    .ev_en  (ien_q),
    .ev_q   (ev_q),
    .irq    (irq)
  );

  assign stat_word  = ev_spread(ev_q);
  assign rx_dma_req = rx_dma_en && rx_rdy_cond;
  assign tx_dma_req = tx_dma_en && tx_req_cond;

  always_comb begin
    case (addr_e)
      A_CTRL:   host_rdata = ctl_pack(ctl_q);
      A_LEVELS: host_rdata = levels_pack(rx_cnt8, tx_cnt8);
      A_IEN:    host_rdata = ev_spread(ien_q);
      A_ISTAT:  host_rdata = stat_word;
      A_RXD:    host_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
      default:  host_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/spfp_checker.sv
module spfp_checker
  import spfp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  host_addr,
  input logic        host_wr,
  input logic        host_rd,
  input logic [31:0] host_wdata,
  input logic        eng_tx_pop,
  input logic        eng_done,
  input logic [7:0]  rx_cnt8,
  input logic [7:0]  tx_cnt8,
  input logic        rx_full,
  input logic        tx_full,
  input logic        rx_flush,
  input logic        tx_flush,
  input logic        rx_rdy_cond,
  input logic        tx_req_cond,
  input logic        rx_ovf_evt,
  input logic        tx_drop,
  input logic [31:0] stat_word,
  input logic        rx_dma_req,
  input logic        rx_dma_en
);

  logic ctl_wr_c, stat_wr_c, rx_pop_c;
  assign ctl_wr_c  = host_wr && (host_addr == 3'd0);
  assign stat_wr_c = host_wr && (host_addr == 3'd3);
  assign rx_pop_c  = host_rd && (host_addr == 3'd5);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt8 <= 8'(DEPTH)) && (tx_cnt8 <= 8'(DEPTH)) && (rx_full == (rx_cnt8 == 8'(DEPTH)))); // R1
  AST_TX_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drop && tx_full && !eng_tx_pop) |=> (tx_cnt8 == 8'(DEPTH))); // R1
  AST_RX_FLUSH_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush && !(ctl_wr_c && host_wdata[RX_FLUSH_BIT])) |=> (!rx_flush && rx_cnt8 == 8'd0)); // R4
  AST_TX_FLUSH_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !(ctl_wr_c && host_wdata[TX_FLUSH_BIT])) |=> (!tx_flush && tx_cnt8 == 8'd0)); // R4
  AST_RXRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy_cond |=> stat_word[0]); // R5
  AST_TXREQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_cond |=> stat_word[4]); // R6
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_evt |=> stat_word[8]); // R7
  AST_OVF_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_evt && !rx_pop_c) |=> (rx_cnt8 == 8'(DEPTH))); // R7
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> stat_word[12]); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[12] && !(stat_wr_c && host_wdata[12])) |=> stat_word[12]); // R9
  AST_RX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> rx_dma_en); // R11

endmodule

bind spi_fifo_pair spfp_checker #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_addr   (host_addr),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_wdata  (host_wdata),
  .eng_tx_pop  (eng_tx_pop),
  .eng_done    (eng_done),
  .rx_cnt8     (rx_cnt8),
  .tx_cnt8     (tx_cnt8),
  .rx_full     (rx_full),
  .tx_full     (tx_full),
  .rx_flush    (rx_flush),
  .tx_flush    (tx_flush),
  .rx_rdy_cond (rx_rdy_cond),
  .tx_req_cond (tx_req_cond),
  .rx_ovf_evt  (rx_ovf_evt),
  .tx_drop     (tx_drop),
  .stat_word   (stat_word),
  .rx_dma_req  (rx_dma_req),
  .rx_dma_en   (rx_dma_en)
);

// File: tb/spi_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_pair_tb_top;

  localparam int DEPTH = 64;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_LEV = 3'd1, AD_IEN = 3'd2,
                         AD_STAT = 3'd3, AD_TXD = 3'd4, AD_RXD = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        eng_tx_pop = 1'b0, eng_tx_avail;
  logic [7:0]  eng_tx_byte;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic        eng_done = 1'b0;
  logic        irq, tx_dma_req, rx_dma_req;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_fifo_pair #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_avail(eng_tx_avail), .eng_tx_byte(eng_tx_byte),
    .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte), .eng_done(eng_done),
    .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    eng_rx_byte = b; eng_rx_push = 1'b1;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] b, output logic av);
    av = eng_tx_avail; b = eng_tx_byte; eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic done_pulse();
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  function automatic logic [7:0] pat_a(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  function automatic logic [7:0] pat_b(input int i);
    return 8'((i * 53 + 3) % 256);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    logic        av;
    int          marks[4];
    marks = '{1, 7, 32, 64};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(AD_LEV, v);  check("R3", v, 32'h0, "levels after reset");
    rd(AD_CTRL, v); check("R2", v, 32'h0, "control after reset");
    check("R10", {31'd0, irq}, 32'd0, "irq after reset");
    check("R12", {31'd0, eng_tx_avail}, 32'd0, "tx avail after reset");

    // R1 / R7: fill receive queue, overflow, drain in order
    wr(AD_CTRL, 32'h0000_00FF);
    for (int i = 0; i < DEPTH; i++) begin
      rx_push(pat_a(i));
      rd(AD_LEV, v); check("R3", v, 32'(i + 1), "rx count while filling");
    end
    wr(AD_STAT, 32'hFFFF_FFFF);
    rx_push(8'hEE);
    tick();
    rd(AD_STAT, v); check("R7", {31'd0, v[8]}, 32'd1, "overflow bit after push into full");
    rd(AD_LEV, v);  check("R7", v, 32'(DEPTH), "rx count held at depth");
    for (int i = 0; i < DEPTH; i++) begin
      rd(AD_RXD, v); check("R1", v, {24'd0, pat_a(i)}, "rx byte order");
    end
    rd(AD_LEV, v); check("R1", v, 32'h0, "rx empty after drain");

    // R12: empty receive read
    rd(AD_RXD, v); check("R12", v, 32'h0, "empty rx read value");
    rd(AD_LEV, v); check("R12", v, 32'h0, "empty rx read count");

    // R5 / R11 / R9: receive mark sweep with DMA enabled
    foreach (marks[m]) begin
      int lim;
      lim = (marks[m] + 2 > DEPTH) ? DEPTH : marks[m] + 2;
      wr(AD_CTRL, 32'h0000_8100 | 32'(marks[m]));
      tick();
      wr(AD_STAT, 32'hFFFF_FFFF);
      for (int n = 1; n <= lim; n++) begin
        rx_push(8'(n));
        check("R11", {31'd0, rx_dma_req}, {31'd0, n >= marks[m]}, "rx dma vs mark");
        tick();
        rd(AD_STAT, v); check("R5", {31'd0, v[0]}, {31'd0, n >= marks[m]}, "rx ready vs mark");
      end
      wr(AD_STAT, 32'h0000_0001);
      tick();
      rd(AD_STAT, v); check("R9", {31'd0, v[0]}, 32'd1, "level bit sets again after clear");
    end

    // R4: receive reset self-clears and leaves transmit alone
    for (int i = 0; i < 3; i++) wr(AD_TXD, 32'(i));
    wr(AD_CTRL, 32'h0002_8005);
    rd(AD_CTRL, v); check("R4", v, 32'h0002_8005, "reset bit visible one cycle");
    rd(AD_CTRL, v); check("R4", v, 32'h0002_0005, "reset bit cleared, marks kept");
    rd(AD_LEV, v);  check("R4", v, 32'h0003_0000, "rx emptied, tx kept");

    // R6 / R11 / R1 / R12: transmit mark crossing
    wr(AD_CTRL, 32'h8104_0000);
    tick();
    for (int i = 0; i < 10; i++) wr(AD_TXD, {24'd0, pat_b(i)});
    wr(AD_STAT, 32'hFFFF_FFFF);
    tick();
    rd(AD_STAT, v); check("R6", {31'd0, v[4]}, 32'd0, "tx request clear above mark");
    check("R11", {31'd0, tx_dma_req}, 32'd0, "tx dma low above mark");
    for (int i = 0; i < 10; i++) begin
      tx_take(b, av);
      check("R1", {24'd0, b}, {24'd0, pat_b(i)}, "tx byte order");
      check("R12", {31'd0, av}, 32'd1, "tx avail while data");
      if (i == 4) check("R11", {31'd0, tx_dma_req}, 32'd0, "tx dma at mark+1");
      if (i == 5) begin
        check("R11", {31'd0, tx_dma_req}, 32'd1, "tx dma at mark");
        tick();
        rd(AD_STAT, v); check("R6", {31'd0, v[4]}, 32'd1, "tx request at mark");
      end
    end
    check("R12", {31'd0, eng_tx_avail}, 32'd0, "tx avail when empty");
    tx_take(b, av);
    rd(AD_LEV, v); check("R12", v, 32'h0, "pop on empty tx ignored");

    // R1: transmit push past full is dropped
    wr(AD_CTRL, 32'h0);
    for (int i = 0; i <= DEPTH; i++) wr(AD_TXD, 32'(i));
    rd(AD_LEV, v); check("R1", v, 32'(DEPTH) << 16, "tx count held at depth");
    for (int i = 0; i < DEPTH; i++) begin
      tx_take(b, av);
      check("R1", {24'd0, b}, 32'(i), "tx byte after drop");
    end

    // R9: all ones clears every bit whose condition is absent
    wr(AD_CTRL, 32'h0000_000A);
    for (int i = 0; i < 3; i++) wr(AD_TXD, 32'(i));
    done_pulse();
    wr(AD_STAT, 32'hFFFF_FFFF);
    tick();
    rd(AD_STAT, v); check("R9", v, 32'h0, "all ones clears");

    // R10: enable mask and irq
    wr(AD_IEN, 32'hFFFF_FFFF);
    rd(AD_IEN, v); check("R10", v, 32'h0000_1111, "enable keeps event positions");
    wr(AD_IEN, 32'h0000_1000);
    tick();
    check("R10", {31'd0, irq}, 32'd0, "irq quiet without event");
    done_pulse();
    check("R10", {31'd0, irq}, 32'd1, "irq on enabled event");
    rd(AD_STAT, v); check("R8", {31'd0, v[12]}, 32'd1, "done bit set");
    wr(AD_STAT, 32'h0);
    rd(AD_STAT, v); check("R9", {31'd0, v[12]}, 32'd1, "writing 0 keeps bit");
    wr(AD_STAT, 32'h0000_1000);
    rd(AD_STAT, v); check("R9", {31'd0, v[12]}, 32'd0, "writing 1 clears bit");
    check("R10", {31'd0, irq}, 32'd0, "irq drops after clear");

    // R9: set wins over simultaneous clear
    host_addr = AD_STAT; host_wdata = 32'h0000_1000; host_wr = 1'b1; eng_done = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; eng_done = 1'b0;
    rd(AD_STAT, v); check("R9", {31'd0, v[12]}, 32'd1, "set beats clear");

    summary();
  end

endmodule